// File: doc/BRIEF.md
# Base and Limit Address Relocation Unit

This block sits between a processor's load/store path and memory and applies a per-process fence to every access. A running process issues logical addresses that begin at zero. The unit checks each logical address against a limit register that holds the largest offset the process may touch. An address that passes the check is added to a base register, and the sum goes to memory as the physical address. An address that fails the check produces a protection fault, and no memory request is issued for it.

The operating system loads the base and limit registers through a small write port. That port only takes effect while the processor is in supervisor mode. A context switch is simply a supervisor write of a new base and limit. After the switch, the same logical addresses land in a different physical region. A write attempted from user mode leaves both registers unchanged and raises a one-cycle privilege fault.

Requests follow a fixed one-cycle handshake. A request presented in one cycle is answered on the next cycle, either with a forwarded memory request or with a protection fault.

Top module: `reloc_fence`

## Requirements
- R1: After reset, base and limit are zero, the limit is unarmed, and every output is low.
- R2: A request sampled at a clock edge is answered exactly one cycle later: `acc_done` is high, and exactly one of `mem_req` or `prot_fault` is high. For a passing address, `mem_paddr` equals base plus logical address.
- R3: A logical address strictly greater than the limit gives `prot_fault` and no `mem_req`. The comparison uses the logical address, before the base is added.
- R4: A logical address exactly equal to the limit is legal and is forwarded.
- R5: If base plus logical address does not fit in AW bits (carry out of the sum), the access is faulted and not forwarded.
- R6: A supervisor write (`sup_mode`=1, `cfg_we`=1) loads base when `cfg_sel`=0 and limit when `cfg_sel`=1. The new value governs requests from the next cycle onward. A request made in the same cycle as the write is judged against the old values.
- R7: A write with `sup_mode`=0 changes neither register and pulses `priv_fault` for exactly one cycle, on the cycle after the write. `priv_fault` is otherwise low.
- R8: After a supervisor reload of base and limit, the same logical address maps to the new physical region.
- R9: Until the limit has been written at least once by a supervisor write, every request is faulted, whatever the base value.
- R10: With no request, `acc_done`, `mem_req` and `prot_fault` are low on the next cycle, and `mem_paddr` is zero whenever `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_mode | input | 1 | Processor is in supervisor mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 base, 1 limit |
| cfg_wdata | input | AW | Register write value |
| acc_req | input | 1 | Access request valid |
| acc_laddr | input | AW | Logical address of the access |
| acc_done | output | 1 | Response valid, one cycle after the request |
| mem_req | output | 1 | Access forwarded to memory |
| mem_paddr | output | AW | Physical address (zero when not forwarded) |
| prot_fault | output | 1 | Access refused: limit, overflow or unarmed |
| priv_fault | output | 1 | User-mode register write was refused |

## Verification
A register write and an access can fall in the same cycle. This matters most at a context switch, where a reload lands on the same edge as an access from the outgoing process. The bench provokes the collision in two ways. Directed steps pair a limit or base write with a request at the boundary address. The random phase draws writes and requests independently, so they overlap often. The bench's reference model judges each request against the register values held before that cycle's write, then applies the write, so any case where the new value leaks into the same-cycle decision appears as a mismatch on `mem_req`, `prot_fault` or `mem_paddr`.

// File: rtl/reloc_fence.sv
module reloc_fence #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sup_mode,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          acc_req,
  input  logic [AW-1:0] acc_laddr,
  output logic          acc_done,
  output logic          mem_req,
  output logic [AW-1:0] mem_paddr,
  output logic          prot_fault,
  output logic          priv_fault
);

  logic [AW-1:0] base_q;
  logic [AW-1:0] limit_q;
  logic          armed_q;

  logic [AW:0]   sum;
  logic          in_range;
  logic          pass;
  logic          wr_ok;

  assign sum      = {1'b0, base_q} + {1'b0, acc_laddr};
  assign in_range = acc_laddr <= limit_q;
  assign pass     = acc_req && armed_q && in_range && !sum[AW];
  assign wr_ok    = cfg_we && sup_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
      armed_q <= 1'b0;
    end else if (wr_ok) begin
      if (cfg_sel) begin
        limit_q <= cfg_wdata;
        armed_q <= 1'b1;
      end else begin
        base_q <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_done   <= 1'b0;
      mem_req    <= 1'b0;
      mem_paddr  <= '0;
      prot_fault <= 1'b0;
      priv_fault <= 1'b0;
    end else begin
      acc_done   <= acc_req;
      mem_req    <= pass;
      mem_paddr  <= pass ? sum[AW-1:0] : '0;
      prot_fault <= acc_req && !pass;
      priv_fault <= cfg_we && !sup_mode;
    end
  end

endmodule

// File: rtl/reloc_fence_chk.sv
module reloc_fence_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sup_mode,
  input logic          cfg_we,
  input logic          acc_req,
  input logic [AW-1:0] acc_laddr,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] limit_q,
  input logic          armed_q,
  input logic          acc_done,
  input logic          mem_req,
  input logic [AW-1:0] mem_paddr,
  input logic          prot_fault,
  input logic          priv_fault
);

  logic [AW:0] chk_sum;
  assign chk_sum = {1'b0, base_q} + {1'b0, acc_laddr};

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |=> (acc_done && (mem_req ^ prot_fault)));

  p_over_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_laddr > limit_q) |=> (prot_fault && !mem_req));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && chk_sum[AW]) |=> (prot_fault && !mem_req));

  p_pass_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && armed_q && acc_laddr <= limit_q && !chk_sum[AW])
      |=> (mem_req && mem_paddr == $past(chk_sum[AW-1:0])));

  p_user_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !sup_mode) |=> (priv_fault && $stable(base_q) && $stable(limit_q)));

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && !sup_mode) |=> !priv_fault);

  p_unarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !armed_q) |=> prot_fault);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |=> (!acc_done && !mem_req && !prot_fault));

  p_zero_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> mem_paddr == '0);

endmodule

bind reloc_fence reloc_fence_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sup_mode(sup_mode), .cfg_we(cfg_we),
  .acc_req(acc_req), .acc_laddr(acc_laddr), .base_q(base_q),
  .limit_q(limit_q), .armed_q(armed_q), .acc_done(acc_done),
  .mem_req(mem_req), .mem_paddr(mem_paddr), .prot_fault(prot_fault),
  .priv_fault(priv_fault)
);

// File: tb/sim_reloc_fence.sv
module sim_reloc_fence;
  localparam int AW = 32;
  localparam time PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sup_mode = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0, acc_req = 1'b0;
  logic [AW-1:0] cfg_wdata = '0, acc_laddr = '0;
  logic          acc_done, mem_req, prot_fault, priv_fault;
  logic [AW-1:0] mem_paddr;

  int checks = 0;
  int fails  = 0;

  logic [AW-1:0] m_base = '0, m_lim = '0;
  logic          m_armed = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  reloc_fence #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sup_mode(sup_mode), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .acc_req(acc_req),
    .acc_laddr(acc_laddr), .acc_done(acc_done), .mem_req(mem_req),
    .mem_paddr(mem_paddr), .prot_fault(prot_fault), .priv_fault(priv_fault)
  );

  function automatic logic exp_pass(input logic r, input logic [AW-1:0] a);
    logic [AW:0] s;
    s = {1'b0, m_base} + {1'b0, a};
    return r && m_armed && (a <= m_lim) && !s[AW];
  endfunction

  task automatic chk(input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic w, input logic s, input logic [AW-1:0] d,
                      input logic r, input logic [AW-1:0] a, input string req);
    logic e_pass;
    logic [AW-1:0] e_addr;
    sup_mode = p; cfg_we = w; cfg_sel = s; cfg_wdata = d; acc_req = r; acc_laddr = a;
    e_pass = exp_pass(r, a);
    e_addr = e_pass ? m_base + a : '0;
    if (w && p) begin
      if (s) begin m_lim = d; m_armed = 1'b1; end
      else m_base = d;
    end
    @(negedge clk);
    chk(req, "acc_done",   {31'b0, acc_done},   {31'b0, r});
    chk(req, "mem_req",    {31'b0, mem_req},    {31'b0, e_pass});
    chk(req, "prot_fault", {31'b0, prot_fault}, {31'b0, r && !e_pass});
    chk(req, "priv_fault", {31'b0, priv_fault}, {31'b0, w && !p});
    chk(req, "mem_paddr",  mem_paddr,           e_addr);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    int unsigned sd;
    sd = 32'd1234;
    void'($urandom(sd));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "acc_done",   {31'b0, acc_done},   '0);
    chk("R1", "mem_req",    {31'b0, mem_req},    '0);
    chk("R1", "prot_fault", {31'b0, prot_fault}, '0);
    chk("R1", "priv_fault", {31'b0, priv_fault}, '0);
    chk("R1", "mem_paddr",  mem_paddr,           '0);
    rst_n = 1'b1;
    // R9 unarmed: address 0 faults, even after base write
    step(0, 0, 0, 0, 1, 32'h0, "R9");
    step(1, 0, 0, 0, 0, 0, "R10");
    step(1, 1, 0, 32'h1000, 1, 32'h0, "R9");
    step(1, 0, 0, 0, 1, 32'h4, "R9");
    // R7 user write to limit ignored, still unarmed
    step(0, 1, 1, 32'hFFFF, 1, 32'h4, "R7");
    step(0, 0, 0, 0, 1, 32'h4, "R7");
    // R6 limit write with same-cycle access judged against old state
    step(1, 1, 1, 32'h100, 1, 32'h10, "R6");
    step(1, 0, 0, 0, 1, 32'h10, "R2");
    step(0, 0, 0, 0, 1, 32'h100, "R4");
    step(0, 0, 0, 0, 1, 32'h101, "R3");
    // R7 user write to base ignored
    step(0, 1, 0, 32'h9000, 1, 32'h20, "R7");
    // R8 context switch: same logical address, new region
    step(1, 1, 0, 32'h5000_0000, 1, 32'h20, "R8");
    step(1, 1, 1, 32'h80, 1, 32'h20, "R8");
    step(0, 0, 0, 0, 1, 32'h20, "R8");
    step(0, 0, 0, 0, 1, 32'h100, "R3");
    // R5 overflow at full limit
    step(1, 1, 0, 32'hFFFF_FF00, 0, 0, "R6");
    step(1, 1, 1, 32'hFFFF_FFFF, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 32'hFF, "R5");
    step(0, 0, 0, 0, 1, 32'h100, "R5");
    step(0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R5");
    // R6 same-cycle base write with access
    step(1, 1, 0, 32'h10, 1, 32'h100, "R6");
    step(0, 0, 0, 0, 1, 32'h100, "R6");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic p, w, s, r;
      logic [AW-1:0] d;
      p = ($urandom % 4) != 0;
      w = ($urandom % 5) == 0;
      s = $urandom % 2;
      d = ($urandom % 3 == 0) ? $urandom : ($urandom % 32'h2000);
      if (s && w && p && $urandom % 8 == 0) d = 32'hFFFF_FFF0;
      r = ($urandom % 4) != 0;
      case ($urandom % 4)
        0: a = m_lim;
        1: a = m_lim + 1;
        2: a = $urandom % 32'h3000;
        default: a = $urandom;
      endcase
      step(p, w, s, d, r, a, "R2");
    end
    step(0, 0, 0, 0, 0, 0, "R10");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule